// File: doc/BRIEF.md
# SCSI Adapter Interrupt and Status Unit

This block holds the interrupt, status and sequence-step registers of a SCSI host adapter. It also holds one configuration byte, and it drives a single level-sensitive interrupt line to the host. The command engine reports what happened through single-cycle strobes: function complete, bus service, disconnect, bus reset, terminal count, and command completion with a status byte. The host acknowledges an interrupt by reading the interrupt register. That read returns the current value and clears the pending state in the same access.

A command completion can arrive while the host has not yet read an earlier interrupt. When that happens, the completion is not lost and does not merge with the earlier event. Its status byte is parked in a one-entry hold slot, and the completion is posted by the next interrupt-register read. The host therefore sees two separate interrupts in order.

All registers sit on the bus clock. Reset is active-low and asynchronous. The interrupt output is a flop that tracks the interrupt bit of the status register.

Top module: `scsi_irq_status`

## Requirements
- R1: `irq_o` is high exactly when bit 7 of `stat_o` is set. It goes high one cycle after an event that sets that bit, and a further event while it is set leaves it high without a drop.
- R2: Each event strobe sets its bit in `intr_o` one cycle later, and bits from earlier events are kept. The bits are: function complete bit 3, bus service bit 4, disconnect bit 5, bus reset bit 7. A terminal-count strobe sets bit 4 of `intr_o` and bit 4 of `stat_o`. Every event raises the interrupt, subject to R7.
- R3: While `rd_intr_i` is high, `intr_o` shows the value held before the read. On the next cycle `intr_o` is 0, bits 7 and 4 of `stat_o` are clear, `seq_o` is 4 and `irq_o` is low, unless R5 or R9 applies.
- R4: A completion strobe that arrives while bit 7 of `stat_o` is set, with no read in that cycle, latches its status byte. It leaves `stat_o` and `cmpl_status_o` unchanged.
- R5: The first interrupt-register read after a deferred completion posts it: one cycle later `stat_o` is 0x83, `irq_o` is high and `cmpl_status_o` is the latched byte. The next read, with no new completion, leaves `irq_o` low.
- R6: A completion strobe that arrives while bit 7 of `stat_o` is clear has the following effects one cycle later: `stat_o` becomes 0x83 (status-phase code 3 plus the interrupt bit), `irq_o` goes high, and `cmpl_status_o` takes the strobe's byte.
- R7: A bus-reset strobe while bit 6 of `cfg1_o` is set still sets bit 7 of `intr_o`, but it does not raise the interrupt.
- R8: After reset, `intr_o`, `stat_o`, `seq_o` and `cmpl_status_o` are 0, `irq_o` is low and `cfg1_o` is 7.
- R9: When a read and an event or completion occur in the same cycle, the read's clearing is applied first and the event after it. The new event's bits and its interrupt survive.
- R10: A write strobe on the configuration port loads the whole byte into `cfg1_o` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_fc_i | input | 1 | Function-complete strobe |
| evt_bs_i | input | 1 | Bus-service strobe |
| evt_dc_i | input | 1 | Disconnect strobe |
| evt_br_i | input | 1 | Bus-reset strobe |
| evt_tc_i | input | 1 | Terminal-count strobe |
| cmpl_i | input | 1 | Command-complete strobe |
| cmpl_byte_i | input | 8 | Status byte carried by the completion |
| rd_intr_i | input | 1 | Host read of the interrupt register |
| cfg1_we_i | input | 1 | Configuration byte write strobe |
| cfg1_wdata_i | input | 8 | Configuration byte write data |
| intr_o | output | 8 | Interrupt register |
| stat_o | output | 8 | Status register |
| seq_o | output | 8 | Sequence-step register |
| cfg1_o | output | 8 | Configuration byte |
| cmpl_status_o | output | 8 | Status byte of the last posted completion |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
The bench sends a completion while an interrupt is still pending. A unit that dropped the completion would never show the second status byte, and one that posted it at once would overwrite the status the host has not yet read. It also checks that a deferred completion is posted only once, and that a read and an event in the same cycle keep the event; a design that cleared last would lose that interrupt. The bus reset is repeated with the report-disable bit set and then clear, to catch a mask tied to the wrong bit or ignored altogether.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;
  localparam int unsigned DW = 8;
  // interrupt register bits
  localparam int unsigned INTR_FC_B  = 3;
  localparam int unsigned INTR_BS_B  = 4;
  localparam int unsigned INTR_DC_B  = 5;
  localparam int unsigned INTR_RST_B = 7;
  // status register bits
  localparam int unsigned STAT_INT_B = 7;
  localparam int unsigned STAT_TC_B  = 4;
  localparam logic [DW-1:0] STAT_PHASE_ST = 8'h03;
  localparam logic [DW-1:0] SEQ_DONE      = 8'h04;
  localparam logic [DW-1:0] CFG1_RST_VAL  = 8'h07;
  localparam int unsigned CFG1_NOREPT_B = 6;

  typedef struct packed {
    logic [DW-1:0] intr_set;
    logic          raise;
    logic          tc_set;
  } evt_effect_t;
endpackage

// File: rtl/scsi_irq_evt_decode.sv
module scsi_irq_evt_decode
  import scsi_irq_pkg::*;
(
  input  logic        fc_i,
  input  logic        bs_i,
  input  logic        dc_i,
  input  logic        br_i,
  input  logic        tc_i,
  input  logic        norept_i,
  output evt_effect_t eff_o
);
  localparam int unsigned NSRC = 5;
  logic [NSRC-1:0]   src;
  logic [NSRC-1:0]   src_raises;
  logic [DW-1:0]     src_bit [NSRC];

  assign src = {tc_i, br_i, dc_i, bs_i, fc_i};
  assign src_bit[0] = DW'(1) << INTR_FC_B;
  assign src_bit[1] = DW'(1) << INTR_BS_B;
  assign src_bit[2] = DW'(1) << INTR_DC_B;
  assign src_bit[3] = DW'(1) << INTR_RST_B;
  assign src_bit[4] = DW'(1) << INTR_BS_B;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    // bus reset may be masked from raising the line
    if (g == 3) begin : g_br
      assign src_raises[g] = src[g] & ~norept_i;
    end else begin : g_oth
      assign src_raises[g] = src[g];
    end
  end

  always_comb begin
    eff_o.intr_set = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (src[i]) eff_o.intr_set = eff_o.intr_set | src_bit[i];
    end
    eff_o.raise  = |src_raises;
    eff_o.tc_set = tc_i;
  end
endmodule

// File: rtl/scsi_irq_defer_slot.sv
module scsi_irq_defer_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic [W-1:0] byte_i,
  input  logic         clr_i,
  output logic         valid_o,
  output logic [W-1:0] byte_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      byte_o  <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      byte_o  <= byte_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
  import scsi_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_fc_i,
  input  logic          evt_bs_i,
  input  logic          evt_dc_i,
  input  logic          evt_br_i,
  input  logic          evt_tc_i,
  input  logic          cmpl_i,
  input  logic [DW-1:0] cmpl_byte_i,
  input  logic          rd_intr_i,
  input  logic          cfg1_we_i,
  input  logic [DW-1:0] cfg1_wdata_i,
  output logic [DW-1:0] intr_o,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] seq_o,
  output logic [DW-1:0] cfg1_o,
  output logic [DW-1:0] cmpl_status_o,
  output logic          irq_o
);
  logic [DW-1:0] intr_q, stat_q, seq_q, cfg1_q, csts_q;
  logic [DW-1:0] intr_d, stat_d, seq_d, cfg1_d, csts_d;
  logic          irq_q;
  logic          def_valid;
  logic [DW-1:0] def_byte;
  logic          def_set, def_clr;
  evt_effect_t   eff;

  scsi_irq_evt_decode u_dec (
    .fc_i     (evt_fc_i),
    .bs_i     (evt_bs_i),
    .dc_i     (evt_dc_i),
    .br_i     (evt_br_i),
    .tc_i     (evt_tc_i),
    .norept_i (cfg1_q[CFG1_NOREPT_B]),
    .eff_o    (eff)
  );

  scsi_irq_defer_slot #(.W(DW)) u_defer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (def_set),
    .byte_i  (cmpl_byte_i),
    .clr_i   (def_clr),
    .valid_o (def_valid),
    .byte_o  (def_byte)
  );

  // order: host read, deferred post, new completion, other events
  always_comb begin
    intr_d  = intr_q;
    stat_d  = stat_q;
    seq_d   = seq_q;
    csts_d  = csts_q;
    cfg1_d  = cfg1_we_i ? cfg1_wdata_i : cfg1_q;
    def_set = 1'b0;
    def_clr = 1'b0;
    if (rd_intr_i) begin
      intr_d = '0;
      stat_d[STAT_TC_B]  = 1'b0;
      stat_d[STAT_INT_B] = 1'b0;
      seq_d  = SEQ_DONE;
      if (def_valid) begin
        stat_d = STAT_PHASE_ST;
        stat_d[STAT_INT_B] = 1'b1;
        csts_d  = def_byte;
        def_clr = 1'b1;
      end
    end
    if (cmpl_i) begin
      if (stat_d[STAT_INT_B]) begin
        def_set = 1'b1;
      end else begin
        stat_d = STAT_PHASE_ST;
        stat_d[STAT_INT_B] = 1'b1;
        csts_d = cmpl_byte_i;
      end
    end
    intr_d = intr_d | eff.intr_set;
    if (eff.tc_set) stat_d[STAT_TC_B]  = 1'b1;
    if (eff.raise)  stat_d[STAT_INT_B] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intr_q <= '0;
      stat_q <= '0;
      seq_q  <= '0;
      cfg1_q <= CFG1_RST_VAL;
      csts_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      intr_q <= intr_d;
      stat_q <= stat_d;
      seq_q  <= seq_d;
      cfg1_q <= cfg1_d;
      csts_q <= csts_d;
      irq_q  <= stat_d[STAT_INT_B];
    end
  end

  assign intr_o        = intr_q;
  assign stat_o        = stat_q;
  assign seq_o         = seq_q;
  assign cfg1_o        = cfg1_q;
  assign cmpl_status_o = csts_q;
  assign irq_o         = irq_q;
endmodule

// File: rtl/scsi_irq_status_chk.sv
module scsi_irq_status_chk
  import scsi_irq_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          evt_fc_i,
  input logic          evt_bs_i,
  input logic          evt_dc_i,
  input logic          evt_br_i,
  input logic          evt_tc_i,
  input logic          cmpl_i,
  input logic          rd_intr_i,
  input logic [DW-1:0] intr_o,
  input logic [DW-1:0] stat_o,
  input logic [DW-1:0] seq_o,
  input logic [DW-1:0] cfg1_o,
  input logic [DW-1:0] cmpl_status_o,
  input logic          irq_o
);
  logic any_evt;
  assign any_evt = evt_fc_i | evt_bs_i | evt_dc_i | evt_br_i | evt_tc_i;

  AST_IRQ_TRACKS_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == stat_o[STAT_INT_B]); // R1

  AST_FC_SETS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_fc_i |=> intr_o[INTR_FC_B] && irq_o); // R2

  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_intr_i && !any_evt && !cmpl_i) |=>
      (intr_o == '0) && (seq_o == SEQ_DONE) && !stat_o[STAT_TC_B]); // R3

  AST_DEFER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && stat_o[STAT_INT_B] && !rd_intr_i) |=>
      $stable(cmpl_status_o) && irq_o); // R4

  AST_CMPL_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_i && !stat_o[STAT_INT_B] && !rd_intr_i) |=>
      irq_o && (stat_o[1:0] == 2'b11)); // R6

  AST_BR_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_br_i && cfg1_o[CFG1_NOREPT_B] && !stat_o[STAT_INT_B] && !rd_intr_i
     && !cmpl_i && !evt_fc_i && !evt_bs_i && !evt_dc_i && !evt_tc_i) |=>
      !irq_o && intr_o[INTR_RST_B]); // R7
endmodule

bind scsi_irq_status scsi_irq_status_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .evt_fc_i      (evt_fc_i),
  .evt_bs_i      (evt_bs_i),
  .evt_dc_i      (evt_dc_i),
  .evt_br_i      (evt_br_i),
  .evt_tc_i      (evt_tc_i),
  .cmpl_i        (cmpl_i),
  .rd_intr_i     (rd_intr_i),
  .intr_o        (intr_o),
  .stat_o        (stat_o),
  .seq_o         (seq_o),
  .cfg1_o        (cfg1_o),
  .cmpl_status_o (cmpl_status_o),
  .irq_o         (irq_o)
);

// File: tb/scsi_irq_status_tb.sv
module scsi_irq_status_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       evt_fc_i = 0, evt_bs_i = 0, evt_dc_i = 0, evt_br_i = 0, evt_tc_i = 0;
  logic       cmpl_i = 0;
  logic [7:0] cmpl_byte_i = '0;
  logic       rd_intr_i = 0;
  logic       cfg1_we_i = 0;
  logic [7:0] cfg1_wdata_i = '0;
  logic [7:0] intr_o, stat_o, seq_o, cfg1_o, cmpl_status_o;
  logic       irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  scsi_irq_status dut_i (.*);

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    evt_fc_i = 0; evt_bs_i = 0; evt_dc_i = 0; evt_br_i = 0; evt_tc_i = 0;
    cmpl_i = 0; rd_intr_i = 0; cfg1_we_i = 0;
  endtask

  // drive at negedge, one clock, sample at next negedge
  task automatic step();
    @(negedge clk_i);
    idle();
  endtask

  task automatic host_read(string req, logic [7:0] exp_before);
    rd_intr_i = 1;
    #1;
    chk(req, "intr value during read", intr_o, exp_before);
    step();
  endtask

  task automatic t_reset();
    chk("R8", "intr", intr_o, 8'h00);
    chk("R8", "stat", stat_o, 8'h00);
    chk("R8", "seq", seq_o, 8'h00);
    chk("R8", "cfg1", cfg1_o, 8'h07);
    chk("R8", "cmpl_status", cmpl_status_o, 8'h00);
    chk("R8", "irq", irq_o, 1'b0);
  endtask

  task automatic t_events_and_read();
    evt_fc_i = 1; step();
    chk("R2", "intr after fc", intr_o, 8'h08);
    chk("R1", "irq after fc", irq_o, 1'b1);
    chk("R1", "stat after fc", stat_o, 8'h80);
    evt_bs_i = 1; step();
    chk("R2", "intr after bs", intr_o, 8'h18);
    chk("R1", "irq stays high", irq_o, 1'b1);
    evt_dc_i = 1; step();
    chk("R2", "intr after dc", intr_o, 8'h38);
    host_read("R3", 8'h38);
    chk("R3", "intr cleared", intr_o, 8'h00);
    chk("R3", "stat cleared", stat_o, 8'h00);
    chk("R3", "seq done", seq_o, 8'h04);
    chk("R3", "irq low", irq_o, 1'b0);
  endtask

  task automatic t_term_count();
    evt_tc_i = 1; step();
    chk("R2", "stat after tc", stat_o, 8'h90);
    chk("R2", "intr after tc", intr_o, 8'h10);
    host_read("R3", 8'h10);
    chk("R3", "tc bit cleared", stat_o, 8'h00);
  endtask

  task automatic t_completion();
    cmpl_i = 1; cmpl_byte_i = 8'h02; step();
    chk("R6", "stat after cmpl", stat_o, 8'h83);
    chk("R6", "irq after cmpl", irq_o, 1'b1);
    chk("R6", "cmpl status", cmpl_status_o, 8'h02);
    host_read("R3", 8'h00);
    chk("R3", "stat after read", stat_o, 8'h03);
    chk("R3", "irq after read", irq_o, 1'b0);
  endtask

  task automatic t_deferred();
    evt_dc_i = 1; step();
    chk("R2", "irq after dc", irq_o, 1'b1);
    cmpl_i = 1; cmpl_byte_i = 8'h55; step();
    chk("R4", "stat held", stat_o, 8'h83);
    chk("R4", "cmpl status held", cmpl_status_o, 8'h02);
    chk("R4", "intr kept", intr_o, 8'h20);
    host_read("R5", 8'h20);
    chk("R5", "stat posted", stat_o, 8'h83);
    chk("R5", "irq posted", irq_o, 1'b1);
    chk("R5", "cmpl status posted", cmpl_status_o, 8'h55);
    chk("R5", "intr cleared", intr_o, 8'h00);
    host_read("R5", 8'h00);
    chk("R5", "no second post", irq_o, 1'b0);
    chk("R5", "stat after second read", stat_o, 8'h03);
  endtask

  task automatic t_bus_reset();
    cfg1_we_i = 1; cfg1_wdata_i = 8'h47; step();
    chk("R10", "cfg1 written", cfg1_o, 8'h47);
    evt_br_i = 1; step();
    chk("R7", "rst bit set", intr_o, 8'h80);
    chk("R7", "irq masked", irq_o, 1'b0);
    host_read("R3", 8'h80);
    cfg1_we_i = 1; cfg1_wdata_i = 8'h07; step();
    chk("R10", "cfg1 restored", cfg1_o, 8'h07);
    evt_br_i = 1; step();
    chk("R2", "rst bit set", intr_o, 8'h80);
    chk("R2", "irq raised by bus reset", irq_o, 1'b1);
    host_read("R3", 8'h80);
  endtask

  task automatic t_same_cycle();
    evt_fc_i = 1; step();
    rd_intr_i = 1; evt_bs_i = 1; step();
    chk("R9", "event kept over read", intr_o, 8'h10);
    chk("R9", "irq kept", irq_o, 1'b1);
    rd_intr_i = 1; cmpl_i = 1; cmpl_byte_i = 8'hA6; step();
    chk("R9", "cmpl posted at once", cmpl_status_o, 8'hA6);
    chk("R9", "stat after read+cmpl", stat_o, 8'h83);
    chk("R9", "irq after read+cmpl", irq_o, 1'b1);
    host_read("R3", 8'h00);
    chk("R3", "irq low at end", irq_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_events_and_read();
    t_term_count();
    t_completion();
    t_deferred();
    t_bus_reset();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule